// File: doc/BRIEF.md
# Systolic Fixed-Point Color Matrix Converter

This block turns one pixel per clock from gamma-corrected RGB into luma/chroma (Y, Cr, Cb) or back again. It computes a 3x4 affine matrix-vector product on a 3x3 grid of processing elements. Each element holds one fixed-point coefficient for each direction. It multiplies the incoming 8-bit component by that coefficient, drops the fractional bits of the product, adds the result to the partial sum from its left neighbour, and registers the new sum. The constant column of the matrix needs no element. Its offset, plus one half for rounding, is the seed that starts each row's chain.

Components enter the array skewed by column, and the direction flag travels with them, so each pixel can choose its own direction. The three row sums are then floored to whole numbers, clamped to 0..255 and registered. A valid flag runs alongside the data. A pixel presented on one clock edge comes out four edges later, and a new pixel can enter on every edge.

Top module: `color_matrix_systolic`

## Requirements
- R1: With `in_inv` = 0 the inputs are (R, G, B) on (src0, src1, src2) and the outputs are (Y, Cr, Cb) on (dst0, dst1, dst2). The outputs use coefficients scaled by 32: Y = 8R+16G+3B, seed 528; Cr = 14R-12G-2B, seed 4112; Cb = -5R-9G+14B, seed 4112.
- R2: With `in_inv` = 1 the inputs are (Y, Cr, Cb) on (src0, src1, src2) and the outputs are (R, G, B) on (dst0, dst1, dst2). The outputs use coefficients scaled by 32: R = 37Y+51Cr, seed -7117; G = 37Y-26Cr-13Cb, seed 4356; B = 37Y+65Cb, seed -8842.
- R3: Each output is floor((weighted sum + seed) / 32). Every seed already includes the offset term rounded to 1/32 plus 16, which is one half, so truncating the sum rounds it to the nearest integer.
- R4: A result below 0 is output as 0, and a result above 255 is output as 255.
- R5: `out_valid` is high exactly four rising edges after a rising edge at which `in_valid` was high. The data for that pixel is on the outputs in the same cycle.
- R6: A new pixel can be accepted on every clock. Pixels sent back to back with different `in_inv` values each get their own direction and come out in the order they went in.
- R7: While `rst_n` is low, `out_valid` and all three outputs are 0. This holds even if reset is asserted while the pipeline is full, and the block converts correctly after reset is released.
- R8: A cycle with `in_valid` low produces no `out_valid` four edges later. While no valid result arrives, the outputs keep the last converted value, whatever `src*` and `in_inv` do.
- R9: No partial sum inside the array wraps for any 8-bit input in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is valid |
| in_inv | input | 1 | 0: RGB to YCrCb, 1: YCrCb to RGB |
| src0 | input | 8 | First input component (R or Y) |
| src1 | input | 8 | Second input component (G or Cr) |
| src2 | input | 8 | Third input component (B or Cb) |
| out_valid | output | 1 | Output pixel is valid |
| dst0 | output | 8 | First output component (Y or R) |
| dst1 | output | 8 | Second output component (Cr or G) |
| dst2 | output | 8 | Third output component (Cb or B) |

## Verification
The bench builds the block with its defaults: 8-bit components, 5 fractional bits, 13-bit coefficients and a 16-bit accumulator. With 5 fractional bits every coefficient and seed is a small integer, so each expected output can be worked out by hand as a floor of an integer ratio. These hand values include the rounding cases that go up and those that go down, and the vectors that saturate at 0 and at 255. The 16-bit accumulator is only just wide enough for the extreme inverse sums, which run from -8842 to 17168 in units of 1/32. The all-255 and all-0 inverse vectors therefore push the no-wrap checks to their edge.

// File: rtl/csc_pkg.sv
package csc_pkg;
   // number of color channels; fixed by the three-port interface
   localparam int NUM_CH = 3;

   // matrix entries in thousandths; column 3 is the affine offset
   function automatic int coef_milli(input bit inv, input int row, input int col);
      int v;
      v = 0;
      if (!inv) begin
         case (row * 4 + col)
            0: v = 257;    1: v = 504;    2: v = 98;     3: v = 16000;
            4: v = 439;    5: v = -368;   6: v = -71;    7: v = 128000;
            8: v = -148;   9: v = -291;   10: v = 439;   11: v = 128000;
            default: v = 0;
         endcase
      end else begin
         case (row * 4 + col)
            0: v = 1164;   1: v = 1596;   2: v = 0;      3: v = -222912;
            4: v = 1164;   5: v = -813;   6: v = -392;   7: v = 135616;
            8: v = 1164;   9: v = 0;      10: v = 2017;  11: v = -276800;
            default: v = 0;
         endcase
      end
      return v;
   endfunction

   // nearest multiple of 2^-frac, ties away from zero
   function automatic int quant(input int milli, input int frac);
      int s;
      s = milli * (1 << frac);
      return (s >= 0) ? (s + 500) / 1000 : (s - 500) / 1000;
   endfunction

   function automatic int coef_q(input bit inv, input int row, input int col, input int frac);
      return quant(coef_milli(inv, row, col), frac);
   endfunction

   // offset plus one half: truncation of the final sum then rounds
   function automatic int seed_q(input bit inv, input int row, input int frac);
      return coef_q(inv, row, 3, frac) + (1 << (frac - 1));
   endfunction
endpackage

// File: rtl/csc_pe.sv
module csc_pe #(
   parameter int COMP_W   = 8,
   parameter int FRAC_W   = 5,
   parameter int COEF_W   = 13,
   parameter int ACC_W    = 16,
   parameter int COEF_FWD = 0,
   parameter int COEF_INV = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_inv,
   input  logic [COMP_W-1:0]       comp,
   input  logic signed [ACC_W-1:0] sum_in,
   output logic signed [ACC_W-1:0] sum_out
);
   localparam int XW = COMP_W + FRAC_W + 1;
   localparam int PW = COEF_W + XW;
   localparam logic signed [COEF_W-1:0] K_FWD = COEF_W'(COEF_FWD);
   localparam logic signed [COEF_W-1:0] K_INV = COEF_W'(COEF_INV);

   generate
      if (PW < ACC_W + FRAC_W) begin : g_bad_width
         $error("csc_pe: product narrower than accumulator plus fraction");
      end
   endgenerate

   logic signed [COEF_W-1:0] k_sel;
   logic signed [XW-1:0]     x_fix;
   logic signed [PW-1:0]     prod;
   logic signed [ACC_W-1:0]  term;

   always_comb begin
      k_sel = sel_inv ? K_INV : K_FWD;
      x_fix = $signed({1'b0, comp, {FRAC_W{1'b0}}});
      prod  = PW'(k_sel) * PW'(x_fix);
      term  = ACC_W'(prod >>> FRAC_W);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sum_out <= '0;
      else        sum_out <= sum_in + term;
   end

   // R9: adding same-signed operands never flips the sign
   p_no_wrap_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_in >= 0 && term >= 0) |=> (sum_out >= 0));
   p_no_wrap_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_in < 0 && term < 0) |=> (sum_out < 0));
endmodule

// File: rtl/csc_row.sv
module csc_row import csc_pkg::*; #(
   parameter int ROW    = 0,
   parameter int COMP_W = 8,
   parameter int FRAC_W = 5,
   parameter int COEF_W = 13,
   parameter int ACC_W  = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_CH-1:0]                inv_col,
   input  logic [NUM_CH-1:0][COMP_W-1:0]    comp_col,
   output logic signed [ACC_W-1:0]          sum
);
   localparam logic signed [ACC_W-1:0] SEED_FWD = ACC_W'(seed_q(1'b0, ROW, FRAC_W));
   localparam logic signed [ACC_W-1:0] SEED_INV = ACC_W'(seed_q(1'b1, ROW, FRAC_W));

   logic signed [ACC_W-1:0] link [NUM_CH+1];

   assign link[0] = inv_col[0] ? SEED_INV : SEED_FWD;

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_col
         csc_pe #(
            .COMP_W  (COMP_W),
            .FRAC_W  (FRAC_W),
            .COEF_W  (COEF_W),
            .ACC_W   (ACC_W),
            .COEF_FWD(coef_q(1'b0, ROW, k, FRAC_W)),
            .COEF_INV(coef_q(1'b1, ROW, k, FRAC_W))
         ) u_pe (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_inv(inv_col[k]),
            .comp   (comp_col[k]),
            .sum_in (link[k]),
            .sum_out(link[k+1])
         );
      end
   endgenerate

   assign sum = link[NUM_CH];
endmodule

// File: rtl/csc_sat.sv
module csc_sat #(
   parameter int COMP_W = 8,
   parameter int FRAC_W = 5,
   parameter int ACC_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld,
   input  logic signed [ACC_W-1:0] sum,
   output logic [COMP_W-1:0]       res
);
   localparam int IW = ACC_W - FRAC_W;
   localparam logic signed [IW-1:0]    TOP  = IW'((1 << COMP_W) - 1);
   localparam logic signed [ACC_W-1:0] OVER = ACC_W'((1 << COMP_W) << FRAC_W);

   generate
      if (IW <= COMP_W) begin : g_bad_width
         $error("csc_sat: integer part must exceed component width");
      end
   endgenerate

   logic signed [IW-1:0] whole;
   logic [COMP_W-1:0]    clipped;

   always_comb begin
      whole = IW'(sum >>> FRAC_W);
      if (whole < 0)        clipped = '0;
      else if (whole > TOP) clipped = '1;
      else                  clipped = whole[COMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   res <= '0;
      else if (vld) res <= clipped;
   end

   p_clamp_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && sum < 0) |=> (res == '0));
   p_clamp_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && sum >= OVER) |=> (res == '1));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> $stable(res));
endmodule

// File: rtl/color_matrix_systolic.sv
module color_matrix_systolic import csc_pkg::*; #(
   parameter int COMP_W = 8,
   parameter int FRAC_W = 5,
   parameter int COEF_W = 13,
   parameter int ACC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_inv,
   input  logic [COMP_W-1:0] src0,
   input  logic [COMP_W-1:0] src1,
   input  logic [COMP_W-1:0] src2,
   output logic              out_valid,
   output logic [COMP_W-1:0] dst0,
   output logic [COMP_W-1:0] dst1,
   output logic [COMP_W-1:0] dst2
);
   // array depth plus the clamp register
   localparam int LAT = NUM_CH + 1;

   generate
      if (ACC_W < COMP_W + FRAC_W + 3) begin : g_bad_acc
         $error("color_matrix_systolic: accumulator too narrow for offsets");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("color_matrix_systolic: at least one fractional bit needed");
      end
   endgenerate

   logic [NUM_CH-1:0][COMP_W-1:0] src_vec;
   logic [COMP_W-1:0]             col_u [NUM_CH];
   logic                          inv_u [NUM_CH];
   logic [NUM_CH-1:0][COMP_W-1:0] col_comp;
   logic [NUM_CH-1:0]             col_inv;
   logic [LAT-1:0]                vld_pipe;
   logic signed [ACC_W-1:0]       row_sum [NUM_CH];
   logic [COMP_W-1:0]             res_u [NUM_CH];

   assign src_vec  = {src2, src1, src0};
   assign inv_u[0] = in_inv;

   // column k sees its component and the direction k cycles late
   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_skew
         if (k == 0) begin : g_direct
            assign col_u[0] = src_vec[0];
         end else begin : g_delay
            logic [COMP_W-1:0] chain [k];
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  for (int j = 0; j < k; j++) chain[j] <= '0;
               end else begin
                  chain[0] <= src_vec[k];
                  for (int j = 1; j < k; j++) chain[j] <= chain[j-1];
               end
            end
            assign col_u[k] = chain[k-1];

            always_ff @(posedge clk) begin
               if (!rst_n) inv_u[k] <= 1'b0;
               else        inv_u[k] <= inv_u[k-1];
            end
         end
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < NUM_CH; k++) begin
         col_comp[k] = col_u[k];
         col_inv[k]  = inv_u[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vld_pipe <= '0;
      else        vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
   end

   generate
      for (genvar r = 0; r < NUM_CH; r++) begin : g_row
         csc_row #(
            .ROW   (r),
            .COMP_W(COMP_W),
            .FRAC_W(FRAC_W),
            .COEF_W(COEF_W),
            .ACC_W (ACC_W)
         ) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .inv_col (col_inv),
            .comp_col(col_comp),
            .sum     (row_sum[r])
         );

         csc_sat #(
            .COMP_W(COMP_W),
            .FRAC_W(FRAC_W),
            .ACC_W (ACC_W)
         ) u_sat (
            .clk  (clk),
            .rst_n(rst_n),
            .vld  (vld_pipe[LAT-2]),
            .sum  (row_sum[r]),
            .res  (res_u[r])
         );
      end
   endgenerate

   assign out_valid = vld_pipe[LAT-1];
   assign dst0      = res_u[0];
   assign dst1      = res_u[1];
   assign dst2      = res_u[2];

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##(LAT-1) out_valid);
   p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##(LAT-1) !out_valid);
endmodule

// File: tb/tb_color_matrix_systolic.sv
`timescale 1ns/1ps
module tb_color_matrix_systolic;
   localparam real CLK_NS = 4.0;
   localparam int  NV     = 12;

   // {inv, s0, s1, s2, e0, e1, e2}
   // R1 forward rows, R2 inverse rows, R3 rounding (3: B 255.4, 11: G 59.2), R4 clamps (5, 7, 11)
   localparam logic [48:0] VEC [NV] = '{
      {1'b0, 8'd0,   8'd0,   8'd0,   8'd16,  8'd128, 8'd128},
      {1'b1, 8'd16,  8'd128, 8'd128, 8'd0,   8'd0,   8'd2},
      {1'b0, 8'd255, 8'd255, 8'd255, 8'd231, 8'd128, 8'd128},
      {1'b1, 8'd235, 8'd128, 8'd128, 8'd253, 8'd251, 8'd255},
      {1'b0, 8'd255, 8'd0,   8'd0,   8'd80,  8'd240, 8'd88},
      {1'b1, 8'd255, 8'd255, 8'd255, 8'd255, 8'd120, 8'd255},
      {1'b0, 8'd0,   8'd255, 8'd0,   8'd144, 8'd32,  8'd56},
      {1'b1, 8'd0,   8'd0,   8'd0,   8'd0,   8'd136, 8'd0},
      {1'b0, 8'd0,   8'd0,   8'd255, 8'd40,  8'd112, 8'd240},
      {1'b1, 8'd0,   8'd0,   8'd255, 8'd0,   8'd32,  8'd241},
      {1'b0, 8'd100, 8'd50,  8'd200, 8'd85,  8'd141, 8'd186},
      {1'b1, 8'd81,  8'd90,  8'd240, 8'd14,  8'd59,  8'd255}
   };

   logic       clk = 1'b0;
   logic       rst_n, in_valid, in_inv, out_valid;
   logic [7:0] src0, src1, src2, dst0, dst1, dst2;

   int n_chk = 0;
   int n_err = 0;
   int rx    = 0;
   bit mon_on = 1'b0;

   always #(CLK_NS / 2.0) clk = ~clk;

   color_matrix_systolic dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv(in_inv),
      .src0(src0), .src1(src1), .src2(src2),
      .out_valid(out_valid), .dst0(dst0), .dst1(dst1), .dst2(dst2)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input bit v, input bit inv, input int a, input int b, input int c);
      in_valid = v;
      in_inv   = inv;
      src0     = 8'(a);
      src1     = 8'(b);
      src2     = 8'(c);
   endtask

   // stream monitor, R6 ordering plus R1/R2 values
   always @(negedge clk) begin
      if (mon_on && out_valid) begin
         if (rx < NV) begin
            logic [48:0] v;
            int          req;
            v   = VEC[rx];
            req = v[48] ? 2 : 1;
            chk(dst0 == v[23:16], $sformatf("R%0d vec %0d dst0", req, rx), dst0, v[23:16]);
            chk(dst1 == v[15:8],  $sformatf("R%0d vec %0d dst1", req, rx), dst1, v[15:8]);
            chk(dst2 == v[7:0],   $sformatf("R%0d vec %0d dst2", req, rx), dst2, v[7:0]);
         end else begin
            chk(1'b0, "R6 extra output beat", rx, NV);
         end
         rx++;
      end
   end

   initial begin
      #(CLK_NS * 200000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      bit seen [5];
      logic [7:0] h0, h1, h2;

      rst_n = 1'b0;
      drive(1'b0, 1'b0, 0, 0, 0);
      repeat (5) @(negedge clk);
      // R7 reset state
      chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
      chk(dst0 == 8'd0, "R7 reset dst0", dst0, 0);
      chk(dst1 == 8'd0, "R7 reset dst1", dst1, 0);
      chk(dst2 == 8'd0, "R7 reset dst2", dst2, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // back-to-back stream with alternating direction: R1 R2 R3 R4 R6
      mon_on = 1'b1;
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VEC[i][48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
         @(negedge clk);
      end
      drive(1'b0, 1'b0, 0, 0, 0);
      repeat (8) @(negedge clk);
      chk(rx == NV, "R6 one result per pixel", rx, NV);
      mon_on = 1'b0;

      // R5 latency of four edges
      drive(1'b1, 1'b0, 255, 0, 0);
      for (int n = 1; n <= 4; n++) begin
         @(negedge clk);
         if (n == 1) drive(1'b0, 1'b0, 0, 0, 0);
         seen[n] = out_valid;
      end
      chk(!seen[1] && !seen[2] && !seen[3], "R5 no early out_valid", seen[3], 0);
      chk(seen[4] == 1'b1, "R5 out_valid after four edges", seen[4], 1);
      chk(dst1 == 8'd240, "R5 data with out_valid", dst1, 240);

      // R8 bubbles: inputs toggle, outputs hold, no valid
      h0 = dst0; h1 = dst1; h2 = dst2;
      for (int n = 0; n < 6; n++) begin
         drive(1'b0, n[0], 255 - n, 17 * n, 200);
         @(negedge clk);
         chk(out_valid == 1'b0, "R8 no valid from bubble", out_valid, 0);
      end
      repeat (4) @(negedge clk);
      chk(dst0 == h0, "R8 dst0 held", dst0, h0);
      chk(dst1 == h1, "R8 dst1 held", dst1, h1);
      chk(dst2 == h2, "R8 dst2 held", dst2, h2);

      // R7 reset while pipeline is full
      for (int n = 0; n < 3; n++) begin
         drive(1'b1, 1'b1, 235, 128, 128);
         @(negedge clk);
      end
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 0, 0, 0);
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 mid-run reset out_valid", out_valid, 0);
      chk(dst0 == 8'd0, "R7 mid-run reset dst0", dst0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R7 flushed pixels dropped", out_valid, 0);
      end

      // R7 recovery: inverse of black chroma, G rounds 136.125 down (R3)
      drive(1'b1, 1'b1, 0, 0, 0);
      @(negedge clk);
      drive(1'b0, 1'b0, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1, "R7 valid after recovery", out_valid, 1);
      chk(dst0 == 8'd0,   "R4 R after recovery", dst0, 0);
      chk(dst1 == 8'd136, "R3 G after recovery", dst1, 136);
      chk(dst2 == 8'd0,   "R4 B after recovery", dst2, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule